// File: doc/BRIEF.md
# Commutation Slew Transition Timer

This block times the transition that a spindle driver makes each time it moves drive from one motor phase to the next. A one-clock commutation request starts a transition. A 2-bit span code picks its length as a whole number of steps. Each step lasts 128 clocks of the master clock, which is nominally 20 MHz. While the transition runs, the block raises a busy flag and presents a ramp position: a step index that begins at zero and rises by one on every step. Downstream drive logic uses this index to blend the outgoing phase into the incoming one. When the last step ends, a one-clock done pulse marks the end of the transition.

One span code turns the timed ramp off. With that code the request completes at once, with a done pulse on the next cycle and no busy period. A separate rate bit picks a fast or a slow edge rate for the drive. The block captures that bit together with the span code when it accepts a request and presents it on an output, so the drive stages see one consistent setting for the whole transition.

A request that arrives while a transition is running starts a new transition from step zero with the newly presented settings. Back-emf sensing, PWM generation and the output power stages are outside this block.

Top module: `slew_xition_timer`

## Requirements
- R1: While reset is asserted and after its release with no request, busy, done, ramp_pos and rate_fast are all 0.
- R2: A request with span_sel = 2'b00 holds busy high and raises done exactly 24*128 = 3072 clocks after the clock edge that samples the request.
- R3: A request with span_sel = 2'b01 raises done exactly 16*128 = 2048 clocks after the sampling edge.
- R4: A request with span_sel = 2'b10 raises done exactly 12*128 = 1536 clocks after the sampling edge.
- R5: A request with span_sel = 2'b11 (bypass) raises done on the cycle after the request, never raises busy, and leaves ramp_pos at 0.
- R6: After a timed request, ramp_pos is 0 and then rises by exactly one every 128 clocks, so it equals m from 128*m clocks after the sampling edge until the next step.
- R7: A timed request accepted while busy restarts the transition: ramp_pos returns to 0 and done follows the full length of the new span code, measured from the new request.
- R8: The span code is captured only when a request is accepted; changing span_sel during a transition does not change its length.
- R9: rate_fast takes the value of fast_slew at each accepted request and keeps it until the next request, whatever fast_slew does in between.
- R10: done is high for exactly one clock. After a transition ends, busy is 0 and ramp_pos is 0.
- R11: A request that arrives in the same cycle as the final step of a running transition restarts the transition, and no done pulse is issued for the interrupted one.
- R12: A bypass request (span_sel = 2'b11) accepted while busy ends the running transition: on the next cycle busy is 0, ramp_pos is 0 and done is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| comm_req | input | 1 | One-clock commutation request |
| span_sel | input | 2 | Span code: 00 = 24 steps, 01 = 16 steps, 10 = 12 steps, 11 = bypass |
| fast_slew | input | 1 | Edge rate choice for the coming transition (1 = fast) |
| busy | output | 1 | A timed transition is running |
| done | output | 1 | One-clock pulse at the end of a transition |
| ramp_pos | output | STEP_W (5) | Current step index; 0 when idle |
| rate_fast | output | 1 | Edge rate captured at the last request |

## Verification
The assertions check, on every cycle, the properties that hold locally. Each step tick is exactly 128 clocks after the previous tick or the start. The ramp is zero whenever the block is idle, and it only holds or rises by one. It stays below the captured step total. done never coincides with busy and lasts one clock. A bypass request gives done on the next cycle. The captured rate holds between requests. Only the bench scenarios can show the absolute transition lengths for each span code, the precise ramp value at chosen cycles, and the outcome of requests that collide with a running or a just-finishing transition. The same applies to the insensitivity to span_sel changes in mid-transition.

// File: rtl/slew_pkg.sv
package slew_pkg;

  typedef enum logic [1:0] {
    SPAN_LONG   = 2'b00,
    SPAN_MID    = 2'b01,
    SPAN_SHORT  = 2'b10,
    SPAN_BYPASS = 2'b11
  } span_sel_e;

  // Number of 128-clock steps a transition lasts for a given span code.
  // Bypass yields zero steps.
  function automatic int span_steps(input logic [1:0] sel,
                                    input int n_long,
                                    input int n_mid,
                                    input int n_short);
    case (span_sel_e'(sel))
      SPAN_LONG:  return n_long;
      SPAN_MID:   return n_mid;
      SPAN_SHORT: return n_short;
      default:    return 0;
    endcase
  endfunction

  // Largest of three step counts, used to size the step counter.
  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  function automatic logic is_bypass(input logic [1:0] sel);
    return span_sel_e'(sel) == SPAN_BYPASS;
  endfunction

endpackage

// File: rtl/slew_prescaler.sv
module slew_prescaler #(
  parameter int TICK_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
  localparam bit POW2 = ((1 << PW) == TICK_DIV);

  logic [PW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = run && at_last && !clear;

  generate
    if (POW2) begin : g_wrap
      // Power-of-two divide: counter wraps on its own.
      always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (run)        cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_reload
      // Other divide ratios: explicit reload at the last count.
      always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (run)        cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/slew_step_counter.sv
module slew_step_counter #(
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              adv,
  input  logic [STEP_W-1:0] total,
  output logic [STEP_W-1:0] step,
  output logic              last
);
  logic [STEP_W-1:0] step_q;
  logic [STEP_W:0]   next_ext;

  assign next_ext = {1'b0, step_q} + 1'b1;
  assign last     = adv && (next_ext == {1'b0, total});
  assign step     = step_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) step_q <= '0;
    else if (last)       step_q <= '0;
    else if (adv)        step_q <= next_ext[STEP_W-1:0];
  end

endmodule

// File: rtl/slew_ctrl.sv
module slew_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic comm_req,
  input  logic req_bypass,
  input  logic last,
  output logic busy,
  output logic done,
  output logic start
);
  logic busy_q, done_q;
  logic busy_d, done_d;

  assign start = comm_req && !req_bypass;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    if (comm_req) begin
      busy_d = !req_bypass;
      done_d = req_bypass;
    end else if (last) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/slew_xition_timer.sv
module slew_xition_timer #(
  parameter int TICK_DIV    = 128,
  parameter int STEPS_LONG  = 24,
  parameter int STEPS_MID   = 16,
  parameter int STEPS_SHORT = 12,
  localparam int STEP_W = $clog2(slew_pkg::max3(STEPS_LONG, STEPS_MID, STEPS_SHORT) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              comm_req,
  input  logic [1:0]        span_sel,
  input  logic              fast_slew,
  output logic              busy,
  output logic              done,
  output logic [STEP_W-1:0] ramp_pos,
  output logic              rate_fast
);
  import slew_pkg::*;

  // Named internal events, visible to the bound checker.
  logic              tick;
  logic              last;
  logic              start;
  logic              req_bypass;
  logic              counter_clear;
  logic [STEP_W-1:0] span_total;
  logic [STEP_W-1:0] span_total_d;
  logic              rate_q;

  assign req_bypass   = is_bypass(span_sel);
  assign span_total_d = STEP_W'(span_steps(span_sel, STEPS_LONG, STEPS_MID, STEPS_SHORT));
  assign counter_clear = comm_req;

  // Settings captured at each accepted request.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      span_total <= '0;
      rate_q     <= 1'b0;
    end else if (comm_req) begin
      rate_q <= fast_slew;
      if (start) span_total <= span_total_d;
    end
  end

  slew_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .comm_req   (comm_req),
    .req_bypass (req_bypass),
    .last       (last),
    .busy       (busy),
    .done       (done),
    .start      (start)
  );

  slew_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (counter_clear),
    .run   (busy),
    .tick  (tick)
  );

  slew_step_counter #(.STEP_W(STEP_W)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (counter_clear),
    .adv   (tick),
    .total (span_total),
    .step  (ramp_pos),
    .last  (last)
  );

  assign rate_fast = rate_q;

endmodule

// File: rtl/slew_timer_checker.sv
module slew_timer_checker #(
  parameter int TICK_DIV = 128,
  parameter int STEP_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              comm_req,
  input logic [1:0]        span_sel,
  input logic              busy,
  input logic              done,
  input logic [STEP_W-1:0] ramp_pos,
  input logic              rate_fast,
  input logic              tick,
  input logic [STEP_W-1:0] span_total
);
  // Cycles since the last tick or start, counted here rather than via $past.
  logic [15:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n || comm_req) gap_q <= '0;
    else if (busy)          gap_q <= tick ? '0 : gap_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == 16'(TICK_DIV - 1)));                                 // R6
  AST_TICK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy);                                                         // R6
  AST_IDLE_RAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ramp_pos == '0));                                            // R10
  AST_RAMP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !comm_req) |=> (!busy || ramp_pos == $past(ramp_pos)
                             || ramp_pos == $past(ramp_pos) + 1'b1));       // R6
  AST_RAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ramp_pos < span_total));                                      // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                        // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !comm_req) |=> !done);                                         // R10
  AST_TIMED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (comm_req && span_sel != 2'b11) |=> (busy && ramp_pos == '0 && !done)); // R7
  AST_BYPASS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (comm_req && span_sel == 2'b11) |=> (done && !busy));                   // R5
  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !comm_req |=> $stable(rate_fast));                                      // R9

endmodule

bind slew_xition_timer slew_timer_checker #(
  .TICK_DIV (TICK_DIV),
  .STEP_W   (STEP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .comm_req   (comm_req),
  .span_sel   (span_sel),
  .busy       (busy),
  .done       (done),
  .ramp_pos   (ramp_pos),
  .rate_fast  (rate_fast),
  .tick       (tick),
  .span_total (span_total)
);

// File: tb/slew_xition_timer_tb.sv
module slew_xition_timer_tb;
  localparam int STEP_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              comm_req = 1'b0;
  logic [1:0]        span_sel = 2'b00;
  logic              fast_slew = 1'b0;
  logic              busy, done, rate_fast;
  logic [STEP_W-1:0] ramp_pos;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  slew_xition_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .comm_req  (comm_req),
    .span_sel  (span_sel),
    .fast_slew (fast_slew),
    .busy      (busy),
    .done      (done),
    .ramp_pos  (ramp_pos),
    .rate_fast (rate_fast)
  );

  // Vector: [15:14] span code, [13] rate bit, [12:0] expected length in clocks.
  localparam logic [15:0] VEC [4] = '{
    {2'b00, 1'b0, 13'(24*128)},
    {2'b01, 1'b1, 13'(16*128)},
    {2'b10, 1'b0, 13'(12*128)},
    {2'b11, 1'b1, 13'd0}
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Drive a one-clock request; returns at the negedge after the sampling edge.
  task automatic pulse(input logic [1:0] sel, input logic fast);
    @(negedge clk);
    comm_req  = 1'b1;
    span_sel  = sel;
    fast_slew = fast;
    @(negedge clk);
    comm_req = 1'b0;
  endtask

  // Count negedges from the current one (count 0) until done is seen.
  task automatic wait_done(output int cnt);
    cnt = 0;
    while (!done && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    int cnt;
    int len;
    // R1: reset state
    idle(3);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 ramp", ramp_pos, 0);
    check("R1 rate", rate_fast, 0);
    rst_n = 1'b1;
    idle(3);
    check("R1 busy after release", busy, 0);
    check("R1 ramp after release", ramp_pos, 0);

    // R2 R3 R4 R5 R6 R9 R10: table walk
    foreach (VEC[i]) begin
      len = int'(VEC[i][12:0]);
      pulse(VEC[i][15:14], VEC[i][13]);
      fast_slew = ~VEC[i][13];
      cnt = 0;
      if (len > 0) begin
        check("R6 ramp at start", ramp_pos, 0);
        check("R2/R3/R4 busy at start", busy, 1);
        while (cnt < 128*5 - 1) begin @(negedge clk); cnt++; end
        check("R6 ramp before step 5", ramp_pos, 4);
        @(negedge clk); cnt++;
        check("R6 ramp at step 5", ramp_pos, 5);
        check("R9 rate held", rate_fast, VEC[i][13]);
        while (!done && cnt < 5000) begin @(negedge clk); cnt++; end
      end else begin
        check("R5 busy never", busy, 0);
        check("R5 ramp zero", ramp_pos, 0);
      end
      case (VEC[i][15:14])
        2'b00: check("R2 length", cnt, len);
        2'b01: check("R3 length", cnt, len);
        2'b10: check("R4 length", cnt, len);
        default: check("R5 length", cnt, len);
      endcase
      check("R10 busy low at done", busy, 0);
      check("R9 rate latched", rate_fast, VEC[i][13]);
      @(negedge clk);
      check("R10 done one cycle", done, 0);
      check("R10 ramp zero after", ramp_pos, 0);
      idle(4);
    end

    // R7: restart while busy
    pulse(2'b00, 1'b0);
    idle(1000);
    pulse(2'b10, 1'b0);
    check("R7 ramp back to zero", ramp_pos, 0);
    wait_done(cnt);
    check("R7 restart length", cnt, 12*128);
    idle(4);

    // R8: span_sel change mid-transition ignored
    pulse(2'b10, 1'b0);
    span_sel = 2'b00;
    wait_done(cnt);
    check("R8 length unchanged", cnt, 12*128);
    idle(4);

    // R11: request on the final step
    pulse(2'b10, 1'b0);
    idle(12*128 - 1);
    comm_req = 1'b1;
    span_sel = 2'b01;
    @(negedge clk);
    comm_req = 1'b0;
    check("R11 no done", done, 0);
    check("R11 busy", busy, 1);
    check("R11 ramp zero", ramp_pos, 0);
    wait_done(cnt);
    check("R11 new length", cnt, 16*128);
    idle(4);

    // R12: bypass aborts a running transition
    pulse(2'b00, 1'b0);
    idle(300);
    pulse(2'b11, 1'b0);
    check("R12 done", done, 1);
    check("R12 busy", busy, 0);
    check("R12 ramp", ramp_pos, 0);
    @(negedge clk);
    check("R12 done one cycle", done, 0);
    idle(4);

    // R1: reset mid-transition
    pulse(2'b01, 1'b1);
    idle(200);
    rst_n = 1'b0;
    idle(2);
    check("R1 reset busy", busy, 0);
    check("R1 reset ramp", ramp_pos, 0);
    check("R1 reset rate", rate_fast, 0);
    rst_n = 1'b1;
    idle(2);

    summary();
  end

endmodule